// File: doc/BRIEF.md
# CAN Frame Timestamp and Interrupt Line Router

This block keeps a free-running count of CAN bit times and latches it when a frame begins on the bus. Receive and transmit starts of frame have separate capture strobes and separate captured values, so each stored message can carry the bit-time stamp of its own start. A select input can replace the internal counter with an externally supplied 16-bit time vector, for example a time base shared across controllers.

The second half of the block gathers single-cycle event pulses into sticky flags. A flag-enable register masks flags, and a line-select register steers each flag to one of two interrupt outputs. A two-bit line-enable register gates each output on its own. Software clears a flag by writing a one to its position. Register writes use a simple strobe, address and data port.

Top module: `can_tsirq_top`

## Requirements
- R1: After reset both captured timestamps, the bit-time counter, all flags, the flag-enable register, the line-select register and the line-enable register are zero, so both interrupt outputs are low.
- R2: The bit-time counter advances by one on each clock cycle with `bit_tick_i` high and keeps its value otherwise.
- R3: The counter wraps from 0xFFFF to 0x0000 and keeps counting.
- R4: A cycle with `rx_sof_i` high loads `rx_ts_o` on that clock edge with the counter value held during that cycle, before any increment in the same cycle. `rx_ts_o` then keeps that value until the next `rx_sof_i`.
- R5: `tx_sof_i` captures into `tx_ts_o` in the same way and independently of the receive side.
- R6: When `ext_ts_sel_i` is high in a capture cycle, the captured value is `ext_ts_i` instead of the counter.
- R7: Flag n is set by a pulse on `evt_i[n]` and stays set. A write to address 0 clears every flag whose data bit is 1. If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: The register at address 2 holds one route bit per flag: 0 sends the flag to `irq0_o` and 1 sends it to `irq1_o`. It resets to all zeros, so every flag goes to `irq0_o`.
- R9: `irq0_o` (`irq1_o`) is high exactly when bit 0 (bit 1) of the line-enable register at address 3 is set and at least one flag is set, enabled in the flag-enable register at address 1, and routed to that line. The outputs follow the register state in the cycle after the updating edge, with no further register.
- R10: An interrupt line whose enable bit is 0 stays low whatever flags are pending. A flag whose enable bit is 0 stays set but drives neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per CAN bit time |
| ext_ts_sel_i | input | 1 | Use the external vector as the timestamp source |
| ext_ts_i | input | 16 | External timestamp vector |
| rx_sof_i | input | 1 | Receive start-of-frame capture strobe |
| tx_sof_i | input | 1 | Transmit start-of-frame capture strobe |
| evt_i | input | 8 | Event pulses, one per flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 clear, 1 flag enable, 2 line select, 3 line enable |
| wr_data_i | input | 8 | Register write data |
| rx_ts_o | output | 16 | Captured receive timestamp |
| tx_ts_o | output | 16 | Captured transmit timestamp |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
Two pairs of functions can coincide in one cycle. A capture strobe can meet a bit tick, and an event pulse can meet a write-one clear of the same flag. The bench drives a capture together with a tick and expects the value from before the increment, including at the 0xFFFF to 0x0000 wrap. It also pulses a flag while clearing it and expects the interrupt line to stay high. A scoreboard model predicts the timestamps and both interrupt lines from the requirements after every driven cycle.

// File: rtl/can_tsirq_pkg.sv
package can_tsirq_pkg;
  localparam int unsigned TS_W_DEF    = 16;
  localparam int unsigned NUM_EVT_DEF = 8;
  localparam int unsigned NUM_LINES   = 2;

  typedef enum logic [1:0] {
    REG_FLAG_CLR = 2'd0,
    REG_FLAG_EN  = 2'd1,
    REG_LINE_SEL = 2'd2,
    REG_LINE_EN  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/can_ts_counter.sv
module can_ts_counter #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_tick_i,
  output logic [TS_W-1:0] cnt_o
);
  localparam logic [TS_W-1:0] CNT_MAX = {TS_W{1'b1}};

  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (bit_tick_i) cnt_q <= cnt_q + TS_W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(cnt_q));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/can_ts_capture.sv
module can_ts_capture #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic            ext_sel_i,
  input  logic [TS_W-1:0] ext_ts_i,
  input  logic [TS_W-1:0] cnt_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q;
  logic [TS_W-1:0] src;

  assign src = ext_sel_i ? ext_ts_i : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ts_q <= '0;
    else if (sof_i) ts_q <= src;
  end

  assign ts_o = ts_q;

  // R4, R5
  ts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(ts_q));

  // R6
  ts_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && ext_sel_i) |=> (ts_q == $past(ext_ts_i)));
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] flags_o
);
  logic [NUM_EVT-1:0] flags_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | evt_i;
  end

  assign flags_o = flags_q;

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt_i) != '0) |=> ((flags_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/can_irq_router.sv
module can_irq_router
  import can_tsirq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [NUM_EVT-1:0]   wr_data_i,
  input  logic [NUM_EVT-1:0]   flags_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_EVT-1:0]   fen_q;
  logic [NUM_EVT-1:0]   sel_q;
  logic [NUM_LINES-1:0] len_q;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q <= '0;
      sel_q <= '0;
      len_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr)
        REG_FLAG_EN:  fen_q <= wr_data_i;
        REG_LINE_SEL: sel_q <= wr_data_i;
        REG_LINE_EN:  len_q <= wr_data_i[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_EVT-1:0] route;
    assign route    = (l == 0) ? ~sel_q : sel_q;
    assign irq_o[l] = len_q[l] & (|(flags_i & fen_q & route));

    // R10
    line_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr == REG_LINE_EN && !wr_data_i[l]) |=> !irq_o[l]);
  end
endmodule

// File: rtl/can_tsirq_top.sv
module can_tsirq_top
  import can_tsirq_pkg::*;
#(
  parameter int unsigned TS_W    = TS_W_DEF,
  parameter int unsigned NUM_EVT = NUM_EVT_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               ext_ts_sel_i,
  input  logic [TS_W-1:0]    ext_ts_i,
  input  logic               rx_sof_i,
  input  logic               tx_sof_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NUM_EVT-1:0] wr_data_i,
  output logic [TS_W-1:0]    rx_ts_o,
  output logic [TS_W-1:0]    tx_ts_o,
  output logic               irq0_o,
  output logic               irq1_o
);
  localparam int unsigned NUM_DIR = 2;

  logic [TS_W-1:0]      cnt;
  logic [NUM_DIR-1:0]   sof;
  logic [TS_W-1:0]      ts [NUM_DIR];
  logic [NUM_EVT-1:0]   clr;
  logic [NUM_EVT-1:0]   flags;
  logic [NUM_LINES-1:0] irq;

  can_ts_counter #(.TS_W(TS_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .cnt_o      (cnt)
  );

  assign sof = {tx_sof_i, rx_sof_i};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_cap
    can_ts_capture #(.TS_W(TS_W)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sof_i     (sof[d]),
      .ext_sel_i (ext_ts_sel_i),
      .ext_ts_i  (ext_ts_i),
      .cnt_i     (cnt),
      .ts_o      (ts[d])
    );
  end

  assign rx_ts_o = ts[0];
  assign tx_ts_o = ts[1];

  assign clr = (wr_en_i && wr_addr_i == REG_FLAG_CLR) ? wr_data_i : '0;

  can_irq_flags #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (clr),
    .flags_o (flags)
  );

  can_irq_router #(.NUM_EVT(NUM_EVT)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .flags_i   (flags),
    .irq_o     (irq)
  );

  assign irq0_o = irq[0];
  assign irq1_o = irq[1];

  // R9
  idle_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> (!irq0_o && !irq1_o));

  // R4
  rx_cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_sof_i && !ext_ts_sel_i) |=> (rx_ts_o == $past(cnt)));
endmodule

// File: tb/can_tsirq_top_tb_top.sv
`timescale 1ns/1ps
module can_tsirq_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_tick_i = 1'b0;
  logic        ext_ts_sel_i = 1'b0;
  logic [15:0] ext_ts_i = '0;
  logic        rx_sof_i = 1'b0;
  logic        tx_sof_i = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [15:0] rx_ts_o, tx_ts_o;
  logic        irq0_o, irq1_o;

  always #4 clk_i = ~clk_i;

  can_tsirq_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i),
    .ext_ts_sel_i(ext_ts_sel_i), .ext_ts_i(ext_ts_i),
    .rx_sof_i(rx_sof_i), .tx_sof_i(tx_sof_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rx_ts_o(rx_ts_o), .tx_ts_o(tx_ts_o), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  typedef struct {
    string       tag;
    logic [15:0] rx;
    logic [15:0] tx;
    logic        i0;
    logic        i1;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic [15:0] m_cnt = '0, m_rx = '0, m_tx = '0;
  logic [7:0]  m_flags = '0, m_fen = '0, m_sel = '0;
  logic [1:0]  m_len = '0;

  task automatic step(input logic tk, input logic rs, input logic ts,
                      input logic es, input logic [15:0] et, input logic [7:0] ev,
                      input logic we, input logic [1:0] wa, input logic [7:0] wd,
                      input string tag, input bit chk);
    logic [7:0] clr;
    exp_t x;
    @(negedge clk_i);
    bit_tick_i = tk; rx_sof_i = rs; tx_sof_i = ts; ext_ts_sel_i = es;
    ext_ts_i = et; evt_i = ev; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    @(posedge clk_i);
    if (rs) m_rx = es ? et : m_cnt;
    if (ts) m_tx = es ? et : m_cnt;
    if (tk) m_cnt = m_cnt + 16'd1;
    clr = (we && wa == 2'd0) ? wd : 8'h00;
    m_flags = (m_flags & ~clr) | ev;
    if (we && wa == 2'd1) m_fen = wd;
    if (we && wa == 2'd2) m_sel = wd;
    if (we && wa == 2'd3) m_len = wd[1:0];
    #1;
    if (chk) begin
      x.tag = tag; x.rx = m_rx; x.tx = m_tx;
      x.i0 = m_len[0] & (|(m_flags & m_fen & ~m_sel));
      x.i1 = m_len[1] & (|(m_flags & m_fen & m_sel));
      q.push_back(x);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, tag, 1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(0, 0, 0, 0, 16'h0, 8'h0, 1, a, d, tag, 1);
  endtask

  task automatic ev(input logic [7:0] v, input string tag);
    step(0, 0, 0, 0, 16'h0, v, 0, 2'd0, 8'h0, tag, 1);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++)
      step(1, 0, 0, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R2", 0);
  endtask

  // monitor
  always begin
    @(posedge clk_i);
    #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (rx_ts_o !== e.rx || tx_ts_o !== e.tx || irq0_o !== e.i0 || irq1_o !== e.i1) begin
        n_bad++;
        $display("FAIL %s: got rx=%h tx=%h irq0=%b irq1=%b, expected rx=%h tx=%h irq0=%b irq1=%b",
                 e.tag, rx_ts_o, tx_ts_o, irq0_o, irq1_o, e.rx, e.tx, e.i0, e.i1);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    idle("R1");
    // R2 / R4: five ticks then receive capture without tick
    tick_n(5);
    step(0, 1, 0, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R2/R4", 1);
    // R5: transmit capture with tick in same cycle takes pre-increment value
    step(1, 0, 1, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R5", 1);
    idle("R4 hold");
    // R6: external source on receive side
    step(1, 1, 0, 1, 16'hA5C3, 8'h0, 0, 2'd0, 8'h0, "R6", 1);
    step(0, 0, 1, 0, 16'h1234, 8'h0, 0, 2'd0, 8'h0, "R6 counter back", 1);
    // R3: wrap
    tick_n(int'(16'hFFFF - m_cnt));
    step(1, 1, 0, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R3 max", 1);
    step(1, 0, 1, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R3 wrap", 1);
    step(0, 1, 0, 0, 16'h0, 8'h0, 0, 2'd0, 8'h0, "R3 continue", 1);
    // R10: flags pending, nothing enabled
    ev(8'h04, "R10 fen off");
    wr(2'd1, 8'hFF, "R10 line off");
    // R9, R8 default route to line 0
    wr(2'd3, 8'h01, "R8 default line0");
    idle("R7 sticky");
    wr(2'd0, 8'h04, "R7 clear");
    idle("R9 no flags");
    // R7 set wins over clear
    step(0, 0, 0, 0, 16'h0, 8'h08, 1, 2'd0, 8'h08, "R7 set wins", 1);
    wr(2'd0, 8'h08, "R7 clear2");
    // R8 route bit 5 to line 1
    wr(2'd2, 8'h20, "R8 sel");
    wr(2'd3, 8'h03, "R9 both en");
    ev(8'h20, "R8 line1");
    ev(8'h01, "R8 both lines");
    wr(2'd3, 8'h01, "R10 line1 off");
    wr(2'd3, 8'h03, "R9 line1 on");
    wr(2'd1, 8'hDF, "R10 fen mask");
    wr(2'd3, 8'h00, "R10 both off");
    wr(2'd3, 8'h02, "R9 line1 only");
    wr(2'd1, 8'hFF, "R9 fen restore");
    wr(2'd0, 8'hFF, "R7 clear all");
    idle("R1 final idle");
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule